// File: doc/BRIEF.md
# Sector protection register unit

This unit sits on the device side of a small serial flash that has four sectors. It holds two per-sector byte registers. The first is a protection register that software can rewrite. The second is a lockdown register that can only be read. From these it decides whether a program or erase aimed at a given 24-bit address may proceed. Commands arrive already decoded by an SPI front end. Each command is a start strobe with a two-bit code, and writes and reads then follow as a stream of data bytes or read pulls.

Sector 0 is split into two sub-sectors. Sub-sector A covers the first 4 KiB of sector 0, and sub-sector B covers the rest. Each sub-sector is guarded by its own bit pair in control byte 0. A separate query port takes an address and an operation kind. One cycle later it answers with a registered allow or deny. Protection bytes count only while the `guard_on` input is high. Lockdown bits always count, and no command can clear them.

Top module: `spr_unit`

## Requirements
- R1: After synchronous reset every protection byte and every lockdown byte reads 0x00, and `rd_valid`, `q_done` and `q_allow` are 0.
- R2: A start with code 2'b00 (protection write) resets the write pointer to byte 0. Each later `wr_valid` byte is stored in sector order 0, 1, 2, 3. A `wr_valid` byte that arrives while no protection write is open changes nothing.
- R3: A write stream longer than the sector count wraps, so the fifth byte written overwrites control byte 0.
- R4: A start with code 2'b01 (protection read) resets the read pointer. Each `rd_pull` then yields the next protection byte on `rd_data`, with `rd_valid` high exactly one cycle after the pull. Pulls past the last byte return 0x00.
- R5: A start with code 2'b10 (lockdown read) returns the lockdown bytes in the same way as R4.
- R6: The target sector index is taken from address bits [17:16]. Within sector 0, an address whose bits [15:12] are all zero lies in sub-sector A, and any other address lies in sub-sector B.
- R7: For sectors 1 to 3, a control byte of exactly 0xFF marks the sector protected. Any other value leaves it unprotected.
- R8: In control byte 0, bits [7:6] equal to 2'b11 protect sub-sector A, and bits [5:4] equal to 2'b11 protect sub-sector B. Each pair acts independently of the other.
- R9: While `guard_on` is 0, protection bytes cause no deny.
- R10: A start with code 2'b11 (lock) together with `cmd_addr` permanently marks the addressed sector as locked. For sector 0 it sets bits [7:6] or [5:4] of lockdown byte 0, and for any other sector it sets that byte to 0xFF. A locked target is denied whatever `guard_on` is, and protection writes never clear a lock.
- R11: `q_done` pulses exactly one cycle after `q_valid`, carrying the answer on `q_allow`. A kind of 2'b00 (read) is always allowed. Kinds 2'b01 (program) and 2'b10 (erase) are denied when the target is locked, or when it is protected while `guard_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_on | input | 1 | Makes protection bytes take effect |
| cmd_valid | input | 1 | Start of a register command |
| cmd_code | input | 2 | 00 prot write, 01 prot read, 10 lock read, 11 lock |
| cmd_addr | input | 24 | Target address for the lock command |
| wr_valid | input | 1 | Data byte strobe for a protection write |
| wr_data | input | 8 | Data byte |
| rd_pull | input | 1 | Request the next register byte |
| rd_valid | output | 1 | Read byte is present |
| rd_data | output | 8 | Read byte |
| q_valid | input | 1 | Access query strobe |
| q_kind | input | 2 | 00 read, 01 program, 10 erase |
| q_addr | input | 24 | Query target address |
| q_done | output | 1 | Query answer present |
| q_allow | output | 1 | 1 allow, 0 deny |

## Verification
The assertions assume that the front end never raises `wr_valid` or `rd_pull` in the same cycle as `cmd_valid`. If it does, the command wins and the byte or pull is dropped. They also assume that `q_kind` 2'b11 does not occur. The stimulus issues each command, byte and pull on its own cycle in the directed part. In the random part it uses only the three defined query kinds, and it leaves any overlap of command and byte strobes to be settled by the same command-first rule in the model.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    CMD_PROT_WR  = 2'b00,
    CMD_PROT_RD  = 2'b01,
    CMD_LOCK_RD  = 2'b10,
    CMD_LOCK_SET = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    M_IDLE      = 2'b00,
    M_WRITE     = 2'b01,
    M_READ_PROT = 2'b10,
    M_READ_LOCK = 2'b11
  } mode_e;

  // True when a control byte guards the target region.
  function automatic logic guard_hit(input logic [7:0] b, input logic sec0, input logic sub_a);
    if (sec0) return sub_a ? (b[7:6] == 2'b11) : (b[5:4] == 2'b11);
    return b == 8'hFF;
  endfunction

endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode #(
  parameter int ADDR_W    = 24,
  parameter int NSEC      = 4,
  parameter int SEC_SHIFT = 16,
  parameter int SUB_SHIFT = 12,
  localparam int SEC_W    = $clog2(NSEC)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEC_W-1:0]  sec,
  output logic              sub_a
);
  logic unused_bits;
  assign unused_bits = ^{addr[ADDR_W-1:SEC_SHIFT+SEC_W], addr[SUB_SHIFT-1:0]};

  always_comb begin
    sec   = addr[SEC_SHIFT +: SEC_W];
    sub_a = (sec == '0) && (addr[SEC_SHIFT-1:SUB_SHIFT] == '0);
  end
endmodule

// File: rtl/spr_prot_bank.sv
module spr_prot_bank #(
  parameter int NSEC   = 4,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  output logic [NSEC*8-1:0] bytes_flat
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(NSEC - 1);

  logic [7:0]       mem [NSEC];
  logic [SEC_W-1:0] wptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
    end else if (start) begin
      wptr <= '0;
    end else if (wr_en) begin
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEC; i++) mem[i] <= 8'h00;
    end else if (wr_en && !start) begin
      mem[wptr] <= wr_byte;
    end
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_out
    assign bytes_flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/spr_lock_bank.sv
module spr_lock_bank #(
  parameter int NSEC   = 4,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic              set_sub_a,
  output logic [NSEC*8-1:0] bytes_flat
);
  for (genvar g = 0; g < NSEC; g++) begin : g_byte
    logic [7:0] lk;
    if (g == 0) begin : g_split
      always_ff @(posedge clk) begin
        if (rst) lk <= 8'h00;
        else if (set_en && set_sec == '0) begin
          if (set_sub_a) lk[7:6] <= 2'b11;
          else           lk[5:4] <= 2'b11;
        end
      end
    end else begin : g_whole
      always_ff @(posedge clk) begin
        if (rst) lk <= 8'h00;
        else if (set_en && set_sec == SEC_W'(g)) lk <= 8'hFF;
      end
    end
    assign bytes_flat[g*8 +: 8] = lk;
  end
endmodule

// File: rtl/spr_unit.sv
module spr_unit #(
  parameter int ADDR_W    = 24,
  parameter int NSEC      = 4,
  parameter int SEC_SHIFT = 16,
  parameter int SUB_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              guard_on,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_pull,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              q_valid,
  input  logic [1:0]        q_kind,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_done,
  output logic              q_allow
);
  import spr_pkg::*;

  localparam int SEC_W = $clog2(NSEC);
  localparam int RP_W  = $clog2(NSEC + 1);
  localparam logic [RP_W-1:0] RP_END = RP_W'(NSEC);

  mode_e           mode_q;
  logic [RP_W-1:0] rptr;
  logic [NSEC*8-1:0] prot_flat, lock_flat;
  logic [7:0] prot_arr [NSEC];
  logic [7:0] lock_arr [NSEC];

  logic wr_start, wr_take, lock_set, pull_ok;
  assign wr_start = cmd_valid && cmd_code == CMD_PROT_WR;
  assign lock_set = cmd_valid && cmd_code == CMD_LOCK_SET;
  assign wr_take  = wr_valid && !cmd_valid && mode_q == M_WRITE;
  assign pull_ok  = rd_pull && !cmd_valid &&
                    (mode_q == M_READ_PROT || mode_q == M_READ_LOCK);

  logic [SEC_W-1:0] lk_sec, q_sec;
  logic             lk_sub_a, q_sub_a;

  spr_addr_decode #(.ADDR_W(ADDR_W), .NSEC(NSEC), .SEC_SHIFT(SEC_SHIFT), .SUB_SHIFT(SUB_SHIFT))
    u_dec_lock (.addr(cmd_addr), .sec(lk_sec), .sub_a(lk_sub_a));

  spr_addr_decode #(.ADDR_W(ADDR_W), .NSEC(NSEC), .SEC_SHIFT(SEC_SHIFT), .SUB_SHIFT(SUB_SHIFT))
    u_dec_query (.addr(q_addr), .sec(q_sec), .sub_a(q_sub_a));

  spr_prot_bank #(.NSEC(NSEC)) u_prot (
    .clk(clk), .rst(rst), .start(wr_start), .wr_en(wr_take),
    .wr_byte(wr_data), .bytes_flat(prot_flat)
  );

  spr_lock_bank #(.NSEC(NSEC)) u_lock (
    .clk(clk), .rst(rst), .set_en(lock_set), .set_sec(lk_sec),
    .set_sub_a(lk_sub_a), .bytes_flat(lock_flat)
  );

  for (genvar g = 0; g < NSEC; g++) begin : g_unpack
    assign prot_arr[g] = prot_flat[g*8 +: 8];
    assign lock_arr[g] = lock_flat[g*8 +: 8];
  end

  // Command mode and read pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE;
      rptr   <= '0;
    end else if (cmd_valid) begin
      rptr <= '0;
      unique case (cmd_code)
        CMD_PROT_WR: mode_q <= M_WRITE;
        CMD_PROT_RD: mode_q <= M_READ_PROT;
        CMD_LOCK_RD: mode_q <= M_READ_LOCK;
        default:     mode_q <= M_IDLE;
      endcase
    end else if (pull_ok && rptr != RP_END) begin
      rptr <= rptr + 1'b1;
    end
  end

  logic [7:0] rd_next;
  always_comb begin
    rd_next = 8'h00;
    if (rptr != RP_END) begin
      rd_next = (mode_q == M_READ_LOCK) ? lock_arr[rptr[SEC_W-1:0]]
                                        : prot_arr[rptr[SEC_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= pull_ok;
      if (pull_ok) rd_data <= rd_next;
    end
  end

  // Access decision
  logic q_sec0, hit_prot, hit_lock, deny;
  always_comb begin
    q_sec0   = (q_sec == '0);
    hit_prot = guard_hit(prot_arr[q_sec], q_sec0, q_sub_a);
    hit_lock = guard_hit(lock_arr[q_sec], q_sec0, q_sub_a);
    deny     = (q_kind != 2'b00) && (hit_lock || (guard_on && hit_prot));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_done  <= 1'b0;
      q_allow <= 1'b0;
    end else begin
      q_done  <= q_valid;
      q_allow <= q_valid && !deny;
    end
  end
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int NSEC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              guard_on,
  input logic              q_valid,
  input logic [1:0]        q_kind,
  input logic              q_done,
  input logic              q_allow,
  input logic              rd_pull,
  input logic              rd_valid,
  input logic [NSEC*8-1:0] lock_flat
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!q_done && !rd_valid && !q_allow));

  a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> q_done);

  a_r11_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> (!q_done && !q_allow));

  a_r11_read_allowed: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_kind == 2'b00) |=> q_allow);

  a_r9_off_unlocked_allowed: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !guard_on && lock_flat == '0) |=> q_allow);

  a_r4_valid_needs_pull: assert property (@(posedge clk) disable iff (rst)
    !rd_pull |=> !rd_valid);

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_flat) & ~lock_flat) == '0));
endmodule

bind spr_unit spr_checker #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst(rst), .guard_on(guard_on), .q_valid(q_valid),
  .q_kind(q_kind), .q_done(q_done), .q_allow(q_allow),
  .rd_pull(rd_pull), .rd_valid(rd_valid), .lock_flat(lock_flat)
);

// File: tb/sim_spr_unit.sv
module sim_spr_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, guard_on, cmd_valid, wr_valid, rd_pull, q_valid;
  logic [1:0] cmd_code, q_kind;
  logic [23:0] cmd_addr, q_addr;
  logic [7:0] wr_data;
  logic rd_valid, q_done, q_allow;
  logic [7:0] rd_data;

  spr_unit u0 (
    .clk(clk), .rst(rst), .guard_on(guard_on), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_pull(rd_pull), .rd_valid(rd_valid),
    .rd_data(rd_data), .q_valid(q_valid), .q_kind(q_kind),
    .q_addr(q_addr), .q_done(q_done), .q_allow(q_allow)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit finished = 0;

  // Behavioural reference
  int prot [4];
  int lock [4];
  int wp, rp, md;           // md: 0 idle, 1 write, 2 read prot, 3 read lock
  bit exp_rv, exp_qd, exp_qa;
  int exp_rd;

  function automatic bit region_hit(int b, int sec, bit in_a);
    if (sec == 0) return in_a ? (((b >> 6) & 3) == 3) : (((b >> 4) & 3) == 3);
    return b == 255;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin prot[i] = 0; lock[i] = 0; end
      wp = 0; rp = 0; md = 0;
      exp_rv = 0; exp_qd = 0; exp_qa = 0; exp_rd = 0;
    end else begin
      int sec; bit in_a; bit deny;
      sec  = (int'(q_addr) >> 16) & 3;
      in_a = (sec == 0) && (((int'(q_addr) >> 12) & 15) == 0);
      deny = (q_kind != 0) && (region_hit(lock[sec], sec, in_a) ||
                               (guard_on && region_hit(prot[sec], sec, in_a)));
      exp_qd = q_valid;
      exp_qa = q_valid && !deny;
      exp_rv = 0;
      if (!cmd_valid && rd_pull && (md == 2 || md == 3)) begin
        exp_rv = 1;
        exp_rd = (rp < 4) ? ((md == 3) ? lock[rp] : prot[rp]) : 0;
        if (rp < 4) rp++;
      end
      if (!cmd_valid && wr_valid && md == 1) begin
        prot[wp] = int'(wr_data);
        wp = (wp + 1) % 4;
      end
      if (cmd_valid) begin
        rp = 0;
        case (cmd_code)
          2'b00: begin md = 1; wp = 0; end
          2'b01: md = 2;
          2'b10: md = 3;
          default: begin
            int ls; bit la;
            md = 0;
            ls = (int'(cmd_addr) >> 16) & 3;
            la = (ls == 0) && (((int'(cmd_addr) >> 12) & 15) == 0);
            if (ls == 0) lock[0] = lock[0] | (la ? 'hC0 : 'h30);
            else         lock[ls] = 255;
          end
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(cur_tag, int'(q_done), int'(exp_qd), "q_done");
      check(cur_tag, int'(rd_valid), int'(exp_rv), "rd_valid");
      if (exp_qd) check(cur_tag, int'(q_allow), int'(exp_qa), "q_allow");
      if (exp_rv) check(cur_tag, int'(rd_data), exp_rd, "rd_data");
    end
  end

  task automatic cmd(logic [1:0] c, logic [23:0] a);
    cmd_valid = 1; cmd_code = c; cmd_addr = a;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wbyte(logic [7:0] d);
    wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pull(int n);
    for (int i = 0; i < n; i++) begin
      rd_pull = 1; @(negedge clk); rd_pull = 0;
    end
    @(negedge clk);
  endtask

  task automatic query(logic [1:0] k, logic [23:0] a);
    q_valid = 1; q_kind = k; q_addr = a;
    @(negedge clk); q_valid = 0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1; guard_on = 1; cmd_valid = 0; cmd_code = 0; cmd_addr = 0;
    wr_valid = 0; wr_data = 0; rd_pull = 0; q_valid = 0; q_kind = 0; q_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    cur_tag = "R1";
    check("R1", int'(q_done), 0, "q_done after reset");
    check("R1", int'(rd_valid), 0, "rd_valid after reset");
    cmd(2'b01, 0); pull(5);
    cmd(2'b10, 0); pull(5);

    // R2: ordered protection write and readback
    cur_tag = "R2";
    cmd(2'b00, 0);
    wbyte(8'hC0); wbyte(8'h00); wbyte(8'hFF); wbyte(8'h12);
    cmd(2'b01, 0); pull(4);
    wbyte(8'h55);             // R2: ignored, not in write mode
    cmd(2'b01, 0); pull(4);

    // R6, R7, R8: decode and protection with guard on
    cur_tag = "R6";
    query(2'b01, 24'h000000); query(2'b01, 24'h000FFF);
    query(2'b10, 24'h001000); query(2'b10, 24'h00FFFF);
    cur_tag = "R7";
    query(2'b01, 24'h020000); query(2'b10, 24'h02FFFF);
    query(2'b01, 24'h030000); query(2'b01, 24'h010000);
    query(2'b01, 24'hFC0000);
    cur_tag = "R11";
    query(2'b00, 24'h020000); query(2'b00, 24'h000000);
    @(negedge clk);

    // R9: guard off
    cur_tag = "R9";
    guard_on = 0;
    query(2'b01, 24'h020000); query(2'b10, 24'h000010);
    guard_on = 1;

    // R3: wraparound, R4: read past end
    cur_tag = "R3";
    cmd(2'b00, 0);
    wbyte(8'h11); wbyte(8'h22); wbyte(8'h33); wbyte(8'h44); wbyte(8'h30);
    cur_tag = "R4";
    cmd(2'b01, 0); pull(6);

    // R8: byte 0 now guards only sub-sector B
    cur_tag = "R8";
    query(2'b10, 24'h001000); query(2'b10, 24'h000000);
    query(2'b01, 24'h00F000);

    // R10: lockdown
    cur_tag = "R10";
    cmd(2'b11, 24'h030004);
    cmd(2'b11, 24'h000100);
    guard_on = 0;
    query(2'b01, 24'h030000); query(2'b10, 24'h000800);
    query(2'b01, 24'h001000); query(2'b00, 24'h030000);
    cur_tag = "R5";
    cmd(2'b10, 0); pull(5);
    cur_tag = "R10";
    cmd(2'b00, 0);
    wbyte(8'h00); wbyte(8'h00); wbyte(8'h00); wbyte(8'h00);
    cmd(2'b10, 0); pull(4);
    query(2'b10, 24'h03ABCD);
    guard_on = 1;

    // R11: random mix against the model
    cur_tag = "R11";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      guard_on  = 1'($urandom_range(0, 1));
      cmd_valid = (r == 0); cmd_code = 2'($urandom_range(0, 3));
      cmd_addr  = {6'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 1)), 12'h0};
      wr_valid  = (r == 1 || r == 2);
      wr_data   = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
      rd_pull   = (r == 3);
      q_valid   = (r >= 4);
      q_kind    = 2'($urandom_range(0, 2));
      q_addr    = {6'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 2)), 12'($urandom)};
      @(negedge clk);
    end
    cmd_valid = 0; wr_valid = 0; rd_pull = 0; q_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule